// File: doc/BRIEF.md
# Wavetable Sound Channel

This block is a single programmable audio voice. Software loads a 32-step waveform of 5-bit amplitudes through an 8-bit register write port. The voice then plays that waveform at a pitch set by a 12-bit period value. A sample-rate enable paces the playback. The current amplitude is multiplied by two independent 4-bit volumes, which gives an unsigned left output and an unsigned right output.

Two other sources can replace the table. In direct mode the processor streams raw 5-bit samples, and each write reaches the outputs on the next clock. In noise mode a 15-bit linear feedback shift register is clocked by the period counter, and its output bit is widened to a full-scale amplitude. Mixing several voices and the conversion to analogue are done outside this block.

Register map, selected by `reg_sel`:
- 0 holds the period bits 7:0.
- 1 holds the period bits 11:8, taken from data bits 3:0.
- 2 is control: bit 7 enables the voice, bit 6 selects direct mode, bit 0 selects noise.
- 3 holds the volumes: bits 7:4 are the left volume and bits 3:0 the right volume.
- 4 is the sample port, which uses data bits 4:0.

Top module: `wt_voice`

## Requirements
- R1: After reset, both outputs are 0. The voice is disabled, the period is 0, both volumes are 0, both table pointers are 0 and the noise register holds 1.
- R2: With the voice enabled and direct mode clear, the sample is the table entry at the read pointer. When noise is selected, the sample is instead 31 if the noise output bit is 1 and 0 if that bit is 0.
- R3: A sample-rate pulse arriving while the voice runs outside direct mode either decrements the period counter or, when the counter is 0, reloads it with the period value held before that write. In the reload case it also advances the read pointer by one (modulo 32) and steps the noise register. The table position therefore moves once every period+1 pulses.
- R4: Each output equals the sample times its volume: left uses register 3 bits 7:4 and right uses bits 3:0. The 9-bit result is unsigned, so the maximum is 465.
- R5: A sample-port write in direct mode stores data bits 4:0 as the sample. The outputs show it one clock after the write. The table, the write pointer and the period counter are left untouched.
- R6: The noise register shifts left and takes bit 14 XOR bit 13 into bit 0. Its output bit is bit 14, and it never becomes 0.
- R7: While the voice is disabled, both outputs are 0. The read pointer, the period counter and the noise register hold their values, so sample-rate pulses have no effect.
- R8: A sample-port write outside direct mode stores data bits 4:0 at the write pointer, then increments the pointer modulo 32. A control write with bit 7 clear returns the write pointer to 0.
- R9: A table write may occur while the voice plays, including to the entry currently at the read pointer. The new value is used from the next clock onward.
- R10: A period write in the same cycle as a counter reload does not alter that reload. The new period applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 to 4) |
| reg_wdata | input | 8 | Register write data |
| smp_tick | input | 1 | Sample-rate enable pulse |
| out_l | output | 9 | Scaled left output |
| out_r | output | 9 | Scaled right output |

## Verification
Two events can fall in the same clock: a table write through the sample port, and a counter reload that moves the read pointer, possibly onto the entry being written. A period write can also coincide with a reload. The bench provokes both by setting short periods and issuing random writes on cycles that carry a sample pulse, with directed cases aimed at the exact reload cycle. A reference model in the bench judges each case: it applies the reload with the old period first and then the writes, and the outputs must match the model on the following clock.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int TBL_DEPTH = 32;
    localparam int SMP_W     = 5;
    localparam int VOL_W     = 4;
    localparam int PER_W     = 12;
    localparam int PTR_W     = $clog2(TBL_DEPTH);
    localparam int OUT_W     = SMP_W + VOL_W;

    localparam logic [2:0] SEL_PER_LO = 3'd0;
    localparam logic [2:0] SEL_PER_HI = 3'd1;
    localparam logic [2:0] SEL_CTRL   = 3'd2;
    localparam logic [2:0] SEL_VOL    = 3'd3;
    localparam logic [2:0] SEL_SMP    = 3'd4;

    typedef struct packed {
        logic [TBL_DEPTH-1:0][SMP_W-1:0] tbl;
        logic [PER_W-1:0]                period;
        logic [VOL_W-1:0]                vol_l;
        logic [VOL_W-1:0]                vol_r;
        logic                            run;
        logic                            direct;
        logic                            noise;
        logic [SMP_W-1:0]                dsmp;
        logic [PTR_W-1:0]                wptr;
        logic [PTR_W-1:0]                rptr;
    } voice_state_t;
endpackage

// File: rtl/wt_pitch_timer.sv
module wt_pitch_timer #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [PER_W-1:0] period,
    output logic             wrap
);
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (step) begin
            if (cnt_q == '0) begin
                cnt_d = period;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10
    reload_old_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == '0) |=> (cnt_q == $past(period)));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
endmodule

// File: rtl/wt_noise_lfsr.sv
module wt_noise_lfsr #(
    parameter int LFSR_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_o
);
    localparam int TAP_A = LFSR_W - 1;
    localparam int TAP_B = LFSR_W - 2;

    logic [LFSR_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (adv) sr_d = {sr_q[LFSR_W-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= LFSR_W'(1);
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q[TAP_A];

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
endmodule

// File: rtl/wt_scale.sv
module wt_scale #(
    parameter int SMP_W = 5,
    parameter int VOL_W = 4
) (
    input  logic                   en,
    input  logic [SMP_W-1:0]       smp,
    input  logic [VOL_W-1:0]       vol,
    output logic [SMP_W+VOL_W-1:0] prod
);
    localparam int OW = SMP_W + VOL_W;

    always_comb begin
        prod = '0;
        if (en) prod = OW'(smp) * OW'(vol);
    end

    // R4
    zero_volume_silent_chk: assert final ((vol != '0) || (prod == '0));
endmodule

// File: rtl/wt_voice.sv
module wt_voice
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       smp_tick,
    output logic [8:0] out_l,
    output logic [8:0] out_r
);
    voice_state_t st_d, st_q;

    logic             step_en;
    logic             wrap;
    logic             noise_bit;
    logic [SMP_W-1:0] cur_smp;
    logic [1:0][OUT_W-1:0] scaled;
    logic [1:0][VOL_W-1:0] vols;

    assign step_en = smp_tick && st_q.run && !st_q.direct;

    wt_pitch_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_en),
        .period (st_q.period),
        .wrap   (wrap)
    );

    wt_noise_lfsr #(.LFSR_W(15)) u_noise (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (wrap),
        .bit_o (noise_bit)
    );

    always_comb begin
        if (st_q.direct)     cur_smp = st_q.dsmp;
        else if (st_q.noise) cur_smp = {SMP_W{noise_bit}};
        else                 cur_smp = st_q.tbl[st_q.rptr];
    end

    always_comb begin
        st_d = st_q;
        if (wrap) st_d.rptr = st_q.rptr + 1'b1;
        if (reg_we) begin
            unique case (reg_sel)
                SEL_PER_LO: st_d.period[7:0] = reg_wdata;
                SEL_PER_HI: st_d.period[PER_W-1:8] = reg_wdata[PER_W-9:0];
                SEL_CTRL: begin
                    st_d.run    = reg_wdata[7];
                    st_d.direct = reg_wdata[6];
                    st_d.noise  = reg_wdata[0];
                    if (!reg_wdata[7]) st_d.wptr = '0;
                end
                SEL_VOL: begin
                    st_d.vol_l = reg_wdata[7:4];
                    st_d.vol_r = reg_wdata[3:0];
                end
                SEL_SMP: begin
                    if (st_q.direct) begin
                        st_d.dsmp = reg_wdata[SMP_W-1:0];
                    end else begin
                        st_d.tbl[st_q.wptr] = reg_wdata[SMP_W-1:0];
                        st_d.wptr           = st_q.wptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vols[0] = st_q.vol_l;
    assign vols[1] = st_q.vol_r;

    for (genvar s = 0; s < 2; s++) begin : g_side
        wt_scale #(.SMP_W(SMP_W), .VOL_W(VOL_W)) u_scale (
            .en   (st_q.run),
            .smp  (cur_smp),
            .vol  (vols[s]),
            .prod (scaled[s])
        );
    end

    assign out_l = scaled[0];
    assign out_r = scaled[1];

    // R7
    idle_position_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |=> $stable(st_q.rptr));

    // R5
    direct_sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_SMP && st_q.direct) |=> (st_q.dsmp == $past(reg_wdata[SMP_W-1:0])));

    // R5
    direct_keeps_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_SMP && st_q.direct) |=> $stable(st_q.wptr));

    // R8
    wptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && !reg_wdata[7]) |=> (st_q.wptr == '0));

    // R3
    pointer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.rptr == $past(st_q.rptr) + 1'b1));
endmodule

// File: tb/wt_voice_bench.sv
module wt_voice_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [2:0] reg_sel;
    logic [7:0] reg_wdata;
    logic       smp_tick;
    logic [8:0] out_l, out_r;

    always #2.5 clk = ~clk;

    wt_voice u_wt_voice (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .smp_tick(smp_tick), .out_l(out_l), .out_r(out_r)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [4:0]  m_tbl [32];
    logic [11:0] m_per, m_cnt;
    logic [3:0]  m_vl, m_vr;
    logic        m_run, m_dir, m_noise;
    logic [4:0]  m_dsmp, m_wptr, m_rptr;
    logic [14:0] m_lfsr;

    function automatic logic [4:0] m_sample();
        if (m_dir)   return m_dsmp;
        if (m_noise) return m_lfsr[14] ? 5'd31 : 5'd0;
        return m_tbl[m_rptr];
    endfunction

    function automatic logic [8:0] m_out(input logic [3:0] v);
        if (!m_run) return 9'd0;
        return 9'(m_sample()) * 9'(v);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_tbl[i] = 5'd0;
        m_per = '0; m_cnt = '0; m_vl = '0; m_vr = '0;
        m_run = 1'b0; m_dir = 1'b0; m_noise = 1'b0;
        m_dsmp = '0; m_wptr = '0; m_rptr = '0; m_lfsr = 15'd1;
    endtask

    task automatic model_step();
        logic old_dir;
        old_dir = m_dir;
        if (smp_tick && m_run && !m_dir) begin
            if (m_cnt == 0) begin
                m_cnt  = m_per;
                m_rptr = m_rptr + 1'b1;
                m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
            end else begin
                m_cnt = m_cnt - 1'b1;
            end
        end
        if (reg_we) begin
            case (reg_sel)
                3'd0: m_per[7:0]  = reg_wdata;
                3'd1: m_per[11:8] = reg_wdata[3:0];
                3'd2: begin
                    m_run = reg_wdata[7]; m_dir = reg_wdata[6]; m_noise = reg_wdata[0];
                    if (!reg_wdata[7]) m_wptr = '0;
                end
                3'd3: begin m_vl = reg_wdata[7:4]; m_vr = reg_wdata[3:0]; end
                3'd4: begin
                    if (old_dir) m_dsmp = reg_wdata[4:0];
                    else begin m_tbl[m_wptr] = reg_wdata[4:0]; m_wptr = m_wptr + 1'b1; end
                end
                default: ;
            endcase
        end
    endtask

    task automatic check_val(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        check_val({tag, " left"},  out_l, m_out(m_vl));
        check_val({tag, " right"}, out_r, m_out(m_vr));
    endtask

    task automatic cyc(input logic we, input logic [2:0] sel, input logic [7:0] d,
                       input logic tk, input string tag);
        reg_we = we; reg_sel = sel; reg_wdata = d; smp_tick = tk;
        model_step();
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string tag);
        cyc(1'b1, sel, d, 1'b0, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20210));
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0; smp_tick = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, outputs zero even with pulses
        check_outs("R1 reset");
        ticks(3, "R1 idle ticks");

        // R8: load table with descending ramp while disabled
        wr(3'd2, 8'h00, "R8 ctrl clear");
        for (int i = 0; i < 32; i++) wr(3'd4, 8'(31 - i), "R8 load");
        wr(3'd3, 8'hF3, "R4 volume");
        wr(3'd0, 8'd2, "R3 period lo");
        wr(3'd2, 8'h80, "R2 enable");
        // R4: entry 0 is 31 -> 465 and 93
        check_val("R4 literal left", out_l, 9'd465);
        check_val("R4 literal right", out_r, 9'd93);
        // R3: period 2 -> move every 3 pulses
        ticks(10, "R3 playback");
        // R9: write table entry at the read pointer on a reload tick
        for (int i = 0; i < 6; i++) cyc(1'b1, 3'd4, 8'(5 + i), 1'b1, "R9 write during play");
        // R10: period change coinciding with reloads
        for (int i = 0; i < 6; i++) cyc(1'b1, 3'd0, 8'(i % 3), 1'b1, "R10 period collide");
        wr(3'd1, 8'hF0, "R10 high nibble ignored bits");
        ticks(8, "R3 after period");
        // R7: disable holds position
        wr(3'd2, 8'h00, "R7 disable");
        ticks(5, "R7 idle");
        wr(3'd2, 8'h80, "R7 resume");
        ticks(4, "R7 resumed");
        // R6: noise mode
        wr(3'd0, 8'd0, "R6 period 0");
        wr(3'd2, 8'h81, "R6 noise on");
        ticks(40, "R6 noise");
        // R5: direct mode
        wr(3'd2, 8'hC0, "R5 direct on");
        for (int i = 0; i < 8; i++) cyc(1'b1, 3'd4, 8'(i * 4 + 3), 1'b1, "R5 direct stream");
        ticks(4, "R5 direct ticks frozen");
        wr(3'd2, 8'h80, "R5 direct off");
        ticks(4, "R2 table again");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic       we, tk;
            logic [2:0] sel;
            logic [7:0] d;
            we  = ($urandom % 10) < 3;
            tk  = ($urandom % 2) == 1;
            sel = 3'($urandom % 5);
            d   = 8'($urandom);
            if (sel == 3'd2) begin
                d[7] = ($urandom % 10) < 8;
                d[6] = ($urandom % 10) < 2;
            end
            if (sel == 3'd0) d = 8'($urandom % 4);
            if (sel == 3'd1) d[3:0] = 4'd0;
            cyc(we, sel, d, tk, "R2 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule